// File: doc/BRIEF.md
# Model-Specific Register Bank with Write Checking

This block holds a small set of 64-bit model-specific registers. Each one answers to a 32-bit selector, the value software supplies as the register number for a read or write. The entry count and each entry's selector, kind, power-on value, protected-bit mask and frozen-bit mask are elaboration parameters. Each 64-bit constant is given as an upper (63:32) and a lower (31:0) half.

A request carries a direction, a selector and 64-bit write data. The response comes one cycle later: read data, or confirmation that a write was applied. A fault flag goes with the response when the write broke the entry's rules or the selector matched nothing. Plain entries (kind 0) check protected and frozen bits. Linear-address entries (kind 1) require a canonical value while the core is in 64-bit mode. Physical-address entries (kind 2) reject bits at or above the configured physical width. A hard reset reloads the power-on values. The soft INIT input leaves every stored value as it is.

The request side is a valid/ready port. `req_ready` is always high, so a request is taken on every cycle where `req_valid` is high. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse that the consumer must take when it appears.

Top module: `msrb_bank`

## Requirements
- R1: While `rst_n` is low, and after it rises, every kind-0 entry holds its power-on value `{RESET_HI, RESET_LO}`, kind-1 and kind-2 entries hold zero, and `rsp_valid` and `rsp_fault` are low.
- R2: `req_ready` is always high. A read taken on clock edge k gives `rsp_valid`=1 and `rsp_rdata` equal to the stored value after edge k. `rsp_fault` is 0 if the selector matched an entry.
- R3: A request whose selector matches no entry gives `rsp_fault`=1 and `rsp_rdata`=0 after the next edge, and no entry changes.
- R4: On a kind-0 entry, a write whose data differs from the stored value in any bit set in `{RSVD_HI, RSVD_LO}` faults and leaves the entry unchanged. Protected bits written with their current value do not fault.
- R5: A kind-0 write that does not fault stores `(current & IGN) | (data & ~IGN)`, where IGN is `{IGN_HI, IGN_LO}`. Frozen bits therefore keep their power-on value.
- R6: On a kind-1 entry with `long_mode`=1, a write faults unless bits 63 down to LIN_BITS-1 of the data are all 0 or all 1. With `long_mode`=0 no check applies. A non-faulting write stores the data in full, and the protected and frozen masks have no effect.
- R7: On a kind-2 entry, a write faults if any data bit at position PHYS_BITS or above is 1. Otherwise the data is stored in full, and the masks have no effect.
- R8: Holding `init` high changes no stored value.
- R9: A write taken on edge k gives a response after edge k with `rsp_valid`=1, `rsp_rdata`=0 and `rsp_fault` set per R3 to R7. Without a new request, both flags are low after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| init | input | 1 | Soft INIT; preserves contents |
| long_mode | input | 1 | Core is in 64-bit mode; enables the canonical check |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 32 | Register selector |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 64 | Read data (0 for writes and faults) |
| rsp_fault | output | 1 | General-protection fault flag |

## Verification
Every response is due exactly one edge after its request. The bench drives a request at a falling edge and samples the response at the next falling edge, half a cycle after the edge that registers it. A write lands on that same edge, so a read issued after it sees the new value. The bench confirms this with a read-back after each write. The single-cycle pulse is checked one further falling edge later.

// File: rtl/msrb_pkg.sv
package msrb_pkg;
  typedef enum logic [1:0] {
    KIND_PLAIN = 2'd0,
    KIND_LIN   = 2'd1,
    KIND_PHYS  = 2'd2
  } kind_e;
  localparam int unsigned DW = 64;
  localparam int unsigned IW = 32;
endpackage

// File: rtl/msrb_lookup.sv
module msrb_lookup #(
  parameter int unsigned N_ENTRY = 4,
  parameter logic [N_ENTRY*32-1:0] ENTRY_IDX = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        index,
  output logic [N_ENTRY-1:0] sel,
  output logic               hit
);
  for (genvar i = 0; i < N_ENTRY; i++) begin : g_cmp
    assign sel[i] = (index == ENTRY_IDX[i*32 +: 32]);
  end
  assign hit = |sel;

  // selectors are distinct, so at most one entry answers (R3)
  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
endmodule

// File: rtl/msrb_rule.sv
module msrb_rule #(
  parameter logic [1:0]  KIND      = 2'd0,
  parameter logic [63:0] RSVD      = '0,
  parameter logic [63:0] IGN       = '0,
  parameter int unsigned LIN_BITS  = 48,
  parameter int unsigned PHYS_BITS = 40
) (
  input  logic [63:0] cur,
  input  logic [63:0] wdata,
  input  logic        long_mode,
  output logic        fault,
  output logic [63:0] merged
);
  import msrb_pkg::*;
  localparam int unsigned TOP_W = 64 - (LIN_BITS - 1);
  localparam logic [63:0] PHYS_LIMIT = ~((64'd1 << PHYS_BITS) - 64'd1);

  logic [TOP_W-1:0] lin_top;
  logic canon_bad, phys_bad, rsvd_bad;

  assign lin_top   = wdata[63:LIN_BITS-1];
  assign canon_bad = long_mode && !((&lin_top) || !(|lin_top));
  assign phys_bad  = |(wdata & PHYS_LIMIT);
  assign rsvd_bad  = |((wdata ^ cur) & RSVD);

  always_comb begin
    case (kind_e'(KIND))
      KIND_LIN: begin
        fault  = canon_bad;
        merged = wdata;
      end
      KIND_PHYS: begin
        fault  = phys_bad;
        merged = wdata;
      end
      default: begin
        fault  = rsvd_bad;
        merged = (cur & IGN) | (wdata & ~IGN);
      end
    endcase
  end
endmodule

// File: rtl/msrb_cell.sv
module msrb_cell #(
  parameter logic [1:0]  KIND      = 2'd0,
  parameter logic [63:0] RST_VAL   = '0,
  parameter logic [63:0] RSVD      = '0,
  parameter logic [63:0] IGN       = '0,
  parameter int unsigned LIN_BITS  = 48,
  parameter int unsigned PHYS_BITS = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        long_mode,
  input  logic        wr_req,
  input  logic [63:0] wdata,
  output logic        fault,
  output logic [63:0] value
);
  localparam logic [63:0] START = (KIND == 2'd0) ? RST_VAL : 64'd0;

  logic [63:0] merged;

  msrb_rule #(
    .KIND(KIND), .RSVD(RSVD), .IGN(IGN),
    .LIN_BITS(LIN_BITS), .PHYS_BITS(PHYS_BITS)
  ) u_rule (
    .cur(value), .wdata(wdata), .long_mode(long_mode),
    .fault(fault), .merged(merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                value <= START;
    else if (wr_req && !fault) value <= merged;
  end

  assert_fault_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && fault) |=> $stable(value));
  assert_init_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (init && !wr_req) |=> $stable(value));

  if (KIND == 2'd2) begin : g_phys
    assert_phys_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (value >> PHYS_BITS) == 64'd0);
  end
endmodule

// File: rtl/msrb_bank.sv
module msrb_bank #(
  parameter int unsigned N_ENTRY   = 4,
  parameter int unsigned LIN_BITS  = 48,
  parameter int unsigned PHYS_BITS = 40,
  parameter logic [N_ENTRY*32-1:0] ENTRY_IDX =
    {32'h0000_0277, 32'hC000_0100, 32'h0000_0010, 32'h0000_002C},
  parameter logic [N_ENTRY*2-1:0]  ENTRY_KIND = {2'd2, 2'd1, 2'd0, 2'd0},
  parameter logic [N_ENTRY*32-1:0] RESET_HI =
    {32'h0000_0000, 32'h0000_0000, 32'h1234_5678, 32'h0000_0001},
  parameter logic [N_ENTRY*32-1:0] RESET_LO =
    {32'h0000_FFFF, 32'h0000_0000, 32'h9ABC_DEF0, 32'h0000_00A5},
  parameter logic [N_ENTRY*32-1:0] RSVD_HI =
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_0000},
  parameter logic [N_ENTRY*32-1:0] RSVD_LO =
    {32'hFFFF_FFFF, 32'h0000_00FF, 32'h0000_0000, 32'h0000_0000},
  parameter logic [N_ENTRY*32-1:0] IGN_HI =
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
  parameter logic [N_ENTRY*32-1:0] IGN_LO =
    {32'h0000_00FF, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'h0000_00F0}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        long_mode,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [31:0] req_index,
  input  logic [63:0] req_wdata,
  output logic        rsp_valid,
  output logic [63:0] rsp_rdata,
  output logic        rsp_fault
);
  logic [N_ENTRY-1:0] sel;
  logic               hit;
  logic [N_ENTRY-1:0] cell_fault;
  logic [63:0]        cell_val [N_ENTRY];
  logic               sel_fault;
  logic [63:0]        sel_val;

  assign req_ready = 1'b1;

  msrb_lookup #(.N_ENTRY(N_ENTRY), .ENTRY_IDX(ENTRY_IDX)) u_lookup (
    .clk(clk), .rst_n(rst_n), .index(req_index), .sel(sel), .hit(hit)
  );

  for (genvar i = 0; i < N_ENTRY; i++) begin : g_cell
    msrb_cell #(
      .KIND     (ENTRY_KIND[i*2 +: 2]),
      .RST_VAL  ({RESET_HI[i*32 +: 32], RESET_LO[i*32 +: 32]}),
      .RSVD     ({RSVD_HI[i*32 +: 32],  RSVD_LO[i*32 +: 32]}),
      .IGN      ({IGN_HI[i*32 +: 32],   IGN_LO[i*32 +: 32]}),
      .LIN_BITS (LIN_BITS),
      .PHYS_BITS(PHYS_BITS)
    ) u_cell (
      .clk(clk), .rst_n(rst_n), .init(init), .long_mode(long_mode),
      .wr_req(req_valid && req_write && sel[i]),
      .wdata(req_wdata),
      .fault(cell_fault[i]),
      .value(cell_val[i])
    );
  end

  always_comb begin
    sel_fault = 1'b0;
    sel_val   = '0;
    for (int i = 0; i < N_ENTRY; i++) begin
      if (sel[i]) begin
        sel_fault = cell_fault[i];
        sel_val   = cell_val[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && (!hit || (req_write && sel_fault));
      rsp_rdata <= (req_valid && hit && !req_write) ? sel_val : '0;
    end
  end

  assert_rsp_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fault));
  assert_miss_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit) |=> (rsp_fault && rsp_rdata == 64'd0));
  assert_write_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == 64'd0));
endmodule

// File: tb/tb_msrb_bank.sv
module tb_msrb_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0;
  logic        long_mode = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_index = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        rsp_fault;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  msrb_bank dut (
    .clk(clk), .rst_n(rst_n), .init(init), .long_mode(long_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_index(req_index), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault)
  );

  // bench view of the default configuration
  localparam logic [31:0] IDX  [4] = '{32'h2C, 32'h10, 32'hC000_0100, 32'h277};
  localparam int          KND  [4] = '{0, 0, 1, 2};
  localparam logic [63:0] RSTV [4] = '{64'h0000_0001_0000_00A5,
                                       64'h1234_5678_9ABC_DEF0, 64'h0, 64'h0};
  localparam logic [63:0] RSV  [4] = '{64'hFFFF_0000_0000_0000, 64'h0,
                                       64'hFF, 64'hFFFF_FFFF_FFFF_FFFF};
  localparam logic [63:0] IGM  [4] = '{64'hF0, 64'hFFFF_0000,
                                       64'hFFFF_FFFF_FFFF_FFFF, 64'hFF};

  logic [63:0] model [4];

  function automatic bit exp_fault(int e, logic [63:0] d, logic lm);
    logic [16:0] top;
    top = d[63:47];
    if (KND[e] == 1) return lm && !(top == '0 || top == '1);
    if (KND[e] == 2) return d[63:40] != '0;
    return ((d ^ model[e]) & RSV[e]) != '0;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(bit wr, logic [31:0] idx, logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_index = idx; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd_check(int e, string req);
    issue(1'b0, IDX[e], 64'h0);
    chk(rsp_valid && !rsp_fault && rsp_rdata == model[e], req, rsp_rdata, model[e]);
  endtask

  task automatic wr_check(int e, logic [63:0] d, string req);
    bit f;
    f = exp_fault(e, d, long_mode);
    issue(1'b1, IDX[e], d);
    chk(rsp_valid && rsp_fault == f && rsp_rdata == 0, req,
        {63'd0, rsp_fault}, {63'd0, f});
    if (!f) begin
      if (KND[e] == 0) model[e] = (model[e] & IGM[e]) | (d & ~IGM[e]);
      else             model[e] = d;
    end
    rd_check(e, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 4; e++) model[e] = (KND[e] == 0) ? RSTV[e] : 64'd0;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !rsp_fault, "R1 outputs in reset", {63'd0, rsp_valid}, 64'd0);
    chk(req_ready, "R2 ready", {63'd0, req_ready}, 64'd1);
    rst_n = 1'b1;
    for (int e = 0; e < 4; e++) rd_check(e, "R1 reset value");

    // R4/R5: walking-one flips on the plain entries
    for (int e = 0; e < 2; e++)
      for (int b = 0; b < 64; b++) wr_check(e, model[e] ^ (64'd1 << b), "R4_R5 walk");
    wr_check(0, 64'h0000_0000_FFFF_FFFF, "R5 frozen nibble");
    wr_check(1, 64'h0, "R5 clear with frozen half");

    // R6: linear entry, long mode on then off
    long_mode = 1'b1;
    for (int b = 0; b < 64; b++) wr_check(2, 64'd1 << b, "R6 canonical walk");
    wr_check(2, 64'hFFFF_8000_0000_0000, "R6 upper canonical");
    wr_check(2, 64'h0000_7FFF_FFFF_FFFF, "R6 lower canonical");
    wr_check(2, 64'hFFFF_0000_0000_0000, "R6 noncanonical");
    wr_check(2, 64'h0000_0000_0000_00AB, "R6 masks unused");
    long_mode = 1'b0;
    wr_check(2, 64'h8000_0000_0000_0001, "R6 no check outside long mode");
    long_mode = 1'b1;

    // R7: physical entry width
    for (int b = 0; b < 64; b++) wr_check(3, (64'd1 << b) | 64'h5A, "R7 width walk");
    wr_check(3, 64'h0000_00FF_FFFF_FFFF, "R7 full width");

    // R3: selectors one bit away from each real one
    for (int e = 0; e < 4; e++)
      for (int k = 0; k < 32; k++) begin
        issue(k[0], IDX[e] ^ (32'd1 << k), 64'hFFFF_FFFF_FFFF_FFFF);
        chk(rsp_valid && rsp_fault && rsp_rdata == 0, "R3 miss", rsp_rdata, 64'd0);
      end
    for (int e = 0; e < 4; e++) rd_check(e, "R3 contents kept");

    // R9: write response then pulse ends
    issue(1'b1, IDX[1], 64'h1);
    model[1] = (model[1] & IGM[1]) | (64'h1 & ~IGM[1]);
    chk(rsp_valid && !rsp_fault && rsp_rdata == 0, "R9 write resp", rsp_rdata, 64'd0);
    @(negedge clk);
    chk(!rsp_valid && !rsp_fault, "R9 single pulse", {63'd0, rsp_valid}, 64'd0);

    // R8: INIT held
    init = 1'b1;
    repeat (5) @(negedge clk);
    for (int e = 0; e < 4; e++) rd_check(e, "R8 init keeps");
    init = 1'b0;

    // R1: hard reset reloads
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int e = 0; e < 4; e++) model[e] = (KND[e] == 0) ? RSTV[e] : 64'd0;
    for (int e = 0; e < 4; e++) rd_check(e, "R1 reload");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule